// File: doc/BRIEF.md
# Block-Mode DMA Channel

This is a single DMA channel that runs in block mode. It has a source address and a destination address. Each of them can count up, count down or stay put after every data unit, and the step is the unit size: one byte or one word. Software sets the number of units in a block and the number of blocks. It also picks one of several trigger lines and turns the channel on. After that, each pulse on the chosen trigger line moves exactly one block through a simple single-beat memory master. Each beat reads from the source and then writes to the destination.

A direction bit marks one side as the block area. At the end of every block, the address on that side goes back to the value it had when the block began, so the same window is used again. The address on the other side keeps moving forward through memory. The per-block unit counter reloads from its saved size at the same moment. When the last block ends, the channel turns itself off and raises an end flag. If the interrupt is enabled, the flag drives the interrupt output until software clears the flag.

Top module: `blk_dma_chan`

## Requirements
- R1: After reset, no memory request is issued, the channel is idle and disabled, and the end flag and interrupt are both low.
- R2: A block starts only while the channel is idle, the enable bit (control bit 0) and the master-enable bit (control bit 1) are both 1, and the trigger line chosen by mode bits [9:6] is high. Pulses on other trigger lines, or while either enable bit is 0, start nothing.
- R3: Each beat reads at the source address and then writes the data read to the destination address. Mode bit 0 = 0 selects bytes (mem_byte high, the low 8 bits carried, upper bits written as zero). Mode bit 0 = 1 selects 16-bit words.
- R4: Each address has its own 2-bit step code: source in mode bits [2:1], destination in mode bits [4:3]. Code 01 adds the unit size (1 or 2) after each beat, code 10 subtracts it, and codes 00 and 11 leave the address unchanged. Addresses wrap at 16 bits.
- R5: A write to the size register (address 2) sets the number of beats per block. The beat counter reloads that number at the end of every block, so every block has the same length.
- R6: Mode bit 5 selects the block area: 0 means the source, 1 means the destination. After each block, the block-area address returns to its value at the start of that block. The other address carries on from where it stopped.
- R7: The block counter (address 3) goes down by one per completed block. When the last block completes, the enable bit clears and the end flag sets, and later trigger pulses move nothing.
- R8: The interrupt output equals the end flag whenever interrupt-enable (control bit 2) is 1, and stays low otherwise. A control write with bit 3 = 1 clears the flag.
- R9: Trigger pulses that arrive during a block are ignored. A started block always runs all its beats.
- R10: Writes to registers 0–4 (source, destination, size, count, mode) are ignored while both enable bits are 1 or a block is in progress. The control register (address 5) is always writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: 0 src, 1 dst, 2 size, 3 count, 4 mode, 5 control |
| cfg_wdata | input | 32 | Register write data |
| trig_in | input | TRIG_N (16) | Activation request lines |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_byte | output | 1 | 1 = byte unit, 0 = word unit |
| mem_addr | output | ADDR_W (16) | Beat byte address |
| mem_wdata | output | DATA_W (16) | Write data |
| mem_rdata | input | DATA_W (16) | Read data |
| mem_ack | input | 1 | Beat completes this cycle |
| run_en | output | 1 | Current enable bit |
| end_flag | output | 1 | Transfer-end flag |
| irq | output | 1 | Transfer-end interrupt |
| busy | output | 1 | A block is in progress |

## Verification
The hardest case to reach is the overlap of block boundaries with addresses that run on. The block-area address has to snap back while the opposite address carries over, and this has to hold for every mix of step codes, unit sizes and direction. At the same moment, stray triggers and locked register writes must not disturb the sequence. The stimulus runs many seeded random configurations over several blocks. In some of them it pulses the chosen trigger again during the block, pulses a neighbouring line while idle, and tries to overwrite the source address while the channel is enabled. Each logged write is then compared with a closed-form address formula per block and beat.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} seq_state_t;

  // register select codes
  localparam logic [2:0] RA_SRC  = 3'd0;
  localparam logic [2:0] RA_DST  = 3'd1;
  localparam logic [2:0] RA_SIZE = 3'd2;
  localparam logic [2:0] RA_CNT  = 3'd3;
  localparam logic [2:0] RA_MODE = 3'd4;
  localparam logic [2:0] RA_CTRL = 3'd5;

  // address step codes
  localparam logic [1:0] STEP_INC = 2'b01;
  localparam logic [1:0] STEP_DEC = 2'b10;

  // signed step (two's complement) applied to an address after one beat
  function automatic logic [31:0] step_delta(input logic [1:0] mode,
                                             input logic word,
                                             input int unsigned word_bytes);
    logic [31:0] mag;
    mag = word ? 32'(word_bytes) : 32'd1;
    case (mode)
      STEP_INC: return mag;
      STEP_DEC: return (~mag) + 32'd1;
      default:  return 32'd0;
    endcase
  endfunction

  function automatic logic step_fixed(input logic [1:0] mode);
    return (mode != STEP_INC) && (mode != STEP_DEC);
  endfunction

endpackage

// File: rtl/dmab_regs.sv
module dmab_regs
  import dmab_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 8,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              busy,
  input  logic              xfer_end,
  output logic              ld_src,
  output logic              ld_dst,
  output logic [ADDR_W-1:0] ld_addr_val,
  output logic              ld_size,
  output logic [BLK_W-1:0]  size_val,
  output logic              ld_count,
  output logic [CNT_W-1:0]  count_val,
  output logic              unit_word,
  output logic [1:0]        src_mode,
  output logic [1:0]        dst_mode,
  output logic              blk_dst,
  output logic [SEL_W-1:0]  trig_sel,
  output logic              run_en,
  output logic              mst_en,
  output logic              int_en,
  output logic              end_flag
);
  localparam int MODE_W = 6 + SEL_W;

  logic [MODE_W-1:0] mode_q;
  logic              locked;
  logic              cfg_ok;
  logic              ctrl_wr;
  logic              unused_wdata;

  assign unused_wdata = ^cfg_wdata;
  assign locked  = (run_en && mst_en) || busy;
  assign cfg_ok  = cfg_we && !locked;
  assign ctrl_wr = cfg_we && (cfg_addr == RA_CTRL);

  assign ld_src      = cfg_ok && (cfg_addr == RA_SRC);
  assign ld_dst      = cfg_ok && (cfg_addr == RA_DST);
  assign ld_size     = cfg_ok && (cfg_addr == RA_SIZE);
  assign ld_count    = cfg_ok && (cfg_addr == RA_CNT);
  assign ld_addr_val = cfg_wdata[ADDR_W-1:0];
  assign size_val    = cfg_wdata[BLK_W-1:0];
  assign count_val   = cfg_wdata[CNT_W-1:0];

  assign unit_word = mode_q[0];
  assign src_mode  = mode_q[2:1];
  assign dst_mode  = mode_q[4:3];
  assign blk_dst   = mode_q[5];
  assign trig_sel  = mode_q[6 +: SEL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      run_en   <= 1'b0;
      mst_en   <= 1'b0;
      int_en   <= 1'b0;
      end_flag <= 1'b0;
    end else begin
      if (cfg_ok && (cfg_addr == RA_MODE)) mode_q <= cfg_wdata[MODE_W-1:0];
      if (ctrl_wr) begin
        mst_en <= cfg_wdata[1];
        int_en <= cfg_wdata[2];
      end
      if (xfer_end) begin
        run_en   <= 1'b0;
        end_flag <= 1'b1;
      end else if (ctrl_wr) begin
        run_en <= cfg_wdata[0];
        if (cfg_wdata[3]) end_flag <= 1'b0;
      end
    end
  end

  // R10
  locked_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && locked && cfg_addr == RA_MODE) |=> $stable(mode_q));

endmodule

// File: rtl/dmab_addr_unit.sv
module dmab_addr_unit
  import dmab_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WORD_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              mark,
  input  logic              step,
  input  logic              restore,
  input  logic [1:0]        mode,
  input  logic              unit_word,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] start_q;
  logic [31:0]       delta;

  assign delta = step_delta(mode, unit_word, WORD_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      start_q <= '0;
    end else begin
      if (ld)           addr <= ld_val;
      else if (restore) addr <= start_q;
      else if (step)    addr <= addr + delta[ADDR_W-1:0];
      if (mark) start_q <= addr;
    end
  end

  // R4
  fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restore && !ld && step_fixed(mode)) |=> $stable(addr));

endmodule

// File: rtl/dmab_seq.sv
module dmab_seq
  import dmab_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BLK_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              trig_hit,
  input  logic              ld_size,
  input  logic [BLK_W-1:0]  size_val,
  input  logic              ld_count,
  input  logic [CNT_W-1:0]  count_val,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic              unit_word,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_byte,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              blk_start,
  output logic              beat_done,
  output logic              blk_end,
  output logic              xfer_end
);
  seq_state_t        st_q;
  logic [BLK_W-1:0]  size_cnt;
  logic [BLK_W-1:0]  size_rl;
  logic [CNT_W-1:0]  blocks_left;
  logic [DATA_W-1:0] data_q;

  assign busy      = (st_q != ST_IDLE);
  assign blk_start = !busy && run && trig_hit;
  assign beat_done = (st_q == ST_WR) && mem_ack;
  assign blk_end   = beat_done && (size_cnt == BLK_W'(1));
  assign xfer_end  = blk_end && (blocks_left == CNT_W'(1));

  assign mem_req   = busy;
  assign mem_we    = (st_q == ST_WR);
  assign mem_byte  = !unit_word;
  assign mem_addr  = (st_q == ST_WR) ? dst_addr : src_addr;
  assign mem_wdata = unit_word ? data_q : {{(DATA_W-8){1'b0}}, data_q[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      size_cnt    <= '0;
      size_rl     <= '0;
      blocks_left <= '0;
      data_q      <= '0;
    end else begin
      if (ld_size) begin
        size_rl  <= size_val;
        size_cnt <= size_val;
      end
      if (ld_count) blocks_left <= count_val;
      case (st_q)
        ST_IDLE: if (blk_start) st_q <= ST_RD;
        ST_RD: if (mem_ack) begin
          data_q <= mem_rdata;
          st_q   <= ST_WR;
        end
        ST_WR: if (mem_ack) begin
          if (blk_end) begin
            size_cnt    <= size_rl;
            blocks_left <= blocks_left - CNT_W'(1);
            st_q        <= ST_IDLE;
          end else begin
            size_cnt <= size_cnt - BLK_W'(1);
            st_q     <= ST_RD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

  // R5
  size_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |=> (size_cnt == size_rl));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |=> (blocks_left == $past(blocks_left) - CNT_W'(1)));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !blk_end) |=> busy);

endmodule

// File: rtl/blk_dma_chan.sv
module blk_dma_chan
  import dmab_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BLK_W  = 8,
  parameter int CNT_W  = 16,
  parameter int TRIG_N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [TRIG_N-1:0] trig_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_byte,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              run_en,
  output logic              end_flag,
  output logic              irq,
  output logic              busy
);
  localparam int SEL_W      = $clog2(TRIG_N);
  localparam int WORD_BYTES = DATA_W / 8;

  logic              ld_src, ld_dst, ld_size, ld_count;
  logic [ADDR_W-1:0] ld_addr_val;
  logic [BLK_W-1:0]  size_val;
  logic [CNT_W-1:0]  count_val;
  logic              unit_word, blk_dst, mst_en, int_en;
  logic [1:0]        src_mode, dst_mode;
  logic [SEL_W-1:0]  trig_sel;
  logic              trig_hit;
  logic              blk_start, beat_done, blk_end, xfer_end;

  logic [1:0]        side_ld;
  logic [1:0]        side_mode [2];
  logic [ADDR_W-1:0] side_addr [2];

  assign trig_hit     = trig_in[trig_sel];
  assign irq          = end_flag && int_en;
  assign side_ld      = {ld_dst, ld_src};
  assign side_mode[0] = src_mode;
  assign side_mode[1] = dst_mode;

  dmab_regs #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .CNT_W(CNT_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy), .xfer_end(xfer_end),
    .ld_src(ld_src), .ld_dst(ld_dst), .ld_addr_val(ld_addr_val),
    .ld_size(ld_size), .size_val(size_val), .ld_count(ld_count),
    .count_val(count_val), .unit_word(unit_word), .src_mode(src_mode),
    .dst_mode(dst_mode), .blk_dst(blk_dst), .trig_sel(trig_sel),
    .run_en(run_en), .mst_en(mst_en), .int_en(int_en), .end_flag(end_flag)
  );

  for (genvar s = 0; s < 2; s++) begin : g_side
    dmab_addr_unit #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_addr (
      .clk(clk), .rst_n(rst_n), .ld(side_ld[s]), .ld_val(ld_addr_val),
      .mark(blk_start), .step(beat_done),
      .restore(blk_end && (blk_dst == 1'(s))),
      .mode(side_mode[s]), .unit_word(unit_word), .addr(side_addr[s])
    );
  end

  dmab_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run_en && mst_en), .trig_hit(trig_hit),
    .ld_size(ld_size), .size_val(size_val), .ld_count(ld_count),
    .count_val(count_val), .src_addr(side_addr[0]), .dst_addr(side_addr[1]),
    .unit_word(unit_word), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy),
    .blk_start(blk_start), .beat_done(beat_done), .blk_end(blk_end),
    .xfer_end(xfer_end)
  );

  // R7
  end_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> (!run_en && end_flag));

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == RA_CTRL && cfg_wdata[3] && !xfer_end) |=> !irq);

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(run_en && mst_en && trig_hit));

endmodule

// File: tb/blk_dma_chan_test.sv
`timescale 1ns/1ps
module blk_dma_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [15:0] trig_in = '0;
  logic        mem_req, mem_we, mem_byte;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ack;
  logic        run_en, end_flag, irq, busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] log_addr [4096];
  logic [15:0] log_data [4096];
  logic        log_byte [4096];
  int          log_n = 0;

  always #4 clk = ~clk;

  function automatic logic [15:0] pat(input logic [15:0] a);
    return (a * 16'd40503) ^ 16'h5A3C;
  endfunction

  function automatic int step_of(input int code, input bit word);
    int u;
    u = word ? 2 : 1;
    if (code == 1) return u;
    if (code == 2) return -u;
    return 0;
  endfunction

  function automatic logic [15:0] addr_at(input int base, input int d, input int n);
    return 16'(base + d * n);
  endfunction

  assign mem_ack   = mem_req;
  assign mem_rdata = pat(mem_addr);

  always @(posedge clk) begin
    if (mem_req && mem_we && mem_ack && log_n < 4096) begin
      log_addr[log_n] <= mem_addr;
      log_data[log_n] <= mem_wdata;
      log_byte[log_n] <= mem_byte;
      log_n <= log_n + 1;
    end
  end

  blk_dma_chan uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trig_in(trig_in), .mem_req(mem_req),
    .mem_we(mem_we), .mem_byte(mem_byte), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .run_en(run_en), .end_flag(end_flag), .irq(irq), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int line, input int len);
    @(negedge clk);
    trig_in[line] = 1'b1;
    repeat (len) @(negedge clk);
    trig_in = '0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic run_case(input int src, input int dst, input bit word,
                          input int sm, input int dm, input bit bdir,
                          input int size, input int cnt, input bit ie,
                          input int sel, input bit noise);
    int base_n, ds, dd, n, sa, da, seen;
    reg_wr(3'd5, 32'h8);                       // disable, clear flag
    reg_wr(3'd0, 32'(src));
    reg_wr(3'd1, 32'(dst));
    reg_wr(3'd2, 32'(size));
    reg_wr(3'd3, 32'(cnt));
    reg_wr(3'd4, 32'(word) | 32'(sm << 1) | 32'(dm << 3) | 32'(bdir) << 5 | 32'(sel << 6));
    reg_wr(3'd5, 32'h3 | (32'(ie) << 2));
    if (noise) begin
      reg_wr(3'd0, 32'h1234);                  // R10: locked, must be ignored
      reg_wr(3'd2, 32'd9);                     // R10: locked, must be ignored
    end
    @(negedge clk);
    base_n = log_n;
    for (int b = 0; b < cnt; b++) begin
      if (noise) begin
        pulse((sel + 1) % 16, 1);              // R2: unselected line
        repeat (3) @(negedge clk);
        chk(!busy && log_n == base_n + b * size, "R2", "unselected line start", int'(busy), 0);
      end
      pulse(sel, noise ? 2 : 1);               // R9: held into the block
      wait_idle();
    end
    @(negedge clk);
    chk(log_n - base_n == size * cnt, "R9", "beat count", log_n - base_n, size * cnt);
    ds = step_of(sm, word);
    dd = step_of(dm, word);
    for (int b = 0; b < cnt; b++) begin
      for (int j = 0; j < size; j++) begin
        n  = b * size + j;
        sa = bdir ? addr_at(src, ds, n) : addr_at(src, ds, j);   // R6
        da = bdir ? addr_at(dst, dd, j) : addr_at(dst, dd, n);
        if (base_n + n < log_n) begin
          chk(log_addr[base_n + n] == 16'(da), "R4", "dst address", log_addr[base_n + n], da);
          if (word)
            chk(log_data[base_n + n] == pat(16'(sa)) && !log_byte[base_n + n], "R3",
                "word data", log_data[base_n + n], pat(16'(sa)));
          else
            chk(log_data[base_n + n] == {8'h00, pat(16'(sa))[7:0]} && log_byte[base_n + n],
                "R3", "byte data", log_data[base_n + n], {8'h00, pat(16'(sa))[7:0]});
        end
      end
    end
    chk(!run_en && end_flag, "R7", "end state", {run_en, end_flag}, 1);
    chk(irq == ie, "R8", "irq follows enable", irq, ie);
    seen = log_n;
    pulse(sel, 1);
    repeat (4) @(negedge clk);
    chk(log_n == seen && !busy, "R7", "trigger after end", log_n - seen, 0);
    reg_wr(3'd5, 32'h8 | (32'(ie) << 2));
    @(negedge clk);
    chk(!irq && !end_flag, "R8", "flag clear", {irq, end_flag}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int seen;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1
    chk(!mem_req && !busy && !run_en && !end_flag && !irq, "R1", "reset outputs",
        {mem_req, busy, run_en, end_flag, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !busy, "R1", "after release", {mem_req, busy}, 0);

    // R2: master enable off blocks the start
    reg_wr(3'd2, 32'd2); reg_wr(3'd3, 32'd1); reg_wr(3'd4, 32'(3 << 6));
    reg_wr(3'd5, 32'h1);
    seen = log_n;
    pulse(3, 1);
    repeat (4) @(negedge clk);
    chk(!busy && log_n == seen, "R2", "master enable low", log_n - seen, 0);

    // directed corners (R3..R6, R9, R10)
    run_case(16'h0100, 16'h8000, 1, 1, 1, 0, 4, 3, 1, 2, 0);
    run_case(16'h0200, 16'h9010, 0, 0, 2, 1, 3, 3, 1, 7, 1);
    run_case(16'h0300, 16'hA000, 1, 2, 3, 0, 1, 4, 0, 15, 1);
    run_case(16'hFFFE, 16'h0001, 1, 1, 2, 1, 2, 2, 1, 0, 0);  // R4 wrap

    for (int t = 0; t < 24; t++) begin
      run_case(int'($urandom & 32'hFFFF), int'($urandom & 32'hFFFF), 1'($urandom),
               int'($urandom % 4), int'($urandom % 4), 1'($urandom),
               int'($urandom % 6) + 1, int'($urandom % 4) + 1, 1'($urandom),
               int'($urandom % 16), 1'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule